// File: doc/BRIEF.md
# Fixed-Priority Interrupt Dispatch Selector

This block keeps one pending bit for each of fourteen interrupt sources and, on each take strobe from the exception-entry sequencer, hands over the single most urgent source that may be taken right now. The chosen source is presented as an encoded id and as a one-hot vector with a valid flag. Both hold until the consumer acknowledges with a ready signal. Vector computation and state saving happen downstream and are not part of this block.

Taking a source may or may not clear its pending bit. Most sources clear when taken. The hypervisor decrementer never clears, and it only competes when its enable bit is set and the processor mode permits it. The decrementer clears only when a configuration input asks for it. The external and critical external sources clear when configured as edge-style and stay pending when configured as level-sensitive. An idle output reports when no bit remains pending. The sequencer uses it to drop its hard-interrupt request.

Top module: `irq_dispatch_sel`

## Requirements
- R1: After a synchronous active-high reset, every pending bit is clear, `disp_vld_o` is 0 and `none_pend_o` is 1.
- R2: Pending bit positions are fixed and also set priority, with bit 0 the most urgent: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 external, 11 doorbell, 12 performance monitor, 13 thermal. On a take, the lowest-numbered eligible pending bit is delivered, and `disp_id_o` equals that bit number.
- R3: A take is accepted only when the output is free, meaning `disp_vld_o` is 0 or `ack_rdy_i` is 1. An accepted take delivers exactly one source. A take while the output is held and unacknowledged has no effect on the output or on the pending bits.
- R4: Once `disp_vld_o` is 1, it and `disp_id_o` hold unchanged until a cycle with `ack_rdy_i` at 1. After that cycle, `disp_vld_o` is 0 unless a new take is accepted in the same cycle.
- R5: Sources 0, 1, 2, 5, 6, 7, 8, 11, 12 and 13 have their pending bit cleared when taken.
- R6: Source 3 is eligible only when `hdec_en_i` is 1 and at least one of these holds: `ee_i` is 1, `hv_i` is 0, or `pr_i` is 1. When it is not eligible, lower-priority sources are considered in its place.
- R7: Taking source 3 never clears its pending bit.
- R8: Taking source 9 clears its bit only when `dec_autoclr_i` is 1.
- R9: Taking source 4 clears its bit only when `cext_lvl_i` is 0, which selects edge-style. Taking source 10 clears its bit only when `ext_lvl_i` is 0.
- R10: A set strobe on a bit in the same cycle that a take clears that bit leaves the bit pending.
- R11: `none_pend_o` is 1 exactly when the whole pending vector is zero. A take with no eligible pending source delivers nothing, and `disp_vld_o` stays 0.
- R12: While `disp_vld_o` is 1, `disp_oh_o` has exactly one bit set, at position `disp_id_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set_i | input | 14 | Per-source set strobes, bit n sets pending bit n |
| take_i | input | 1 | Dispatch attempt strobe |
| ack_rdy_i | input | 1 | Consumer accepts the held dispatch |
| dec_autoclr_i | input | 1 | Decrementer clears when taken |
| ext_lvl_i | input | 1 | External source is level-sensitive (1) or edge-style (0) |
| cext_lvl_i | input | 1 | Critical external source is level-sensitive (1) or edge-style (0) |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| ee_i | input | 1 | External-enable mode bit |
| hv_i | input | 1 | Hypervisor mode bit |
| pr_i | input | 1 | Problem-state mode bit |
| disp_vld_o | output | 1 | Dispatch held and valid |
| disp_id_o | output | 4 | Encoded id of the dispatched source |
| disp_oh_o | output | 14 | One-hot id of the dispatched source |
| none_pend_o | output | 1 | No pending bit remains |

## Verification
Each source is raised alone under both settings of the configurable clear inputs. The delivered id shows where its bit sits, and the idle flag after acknowledge, together with a second take, shows whether the bit was cleared. Every pair of sources is then raised together, which shows that the whole fourteen-level order holds and not just its neighbours. All sixteen combinations of enable and mode bits are applied with the hypervisor decrementer and the thermal source both pending, which separates gated from eligible cases. Separate cases cover takes while the output is held, and a set that coincides with a clear.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int unsigned NSRC = 14;
   localparam int unsigned IDW  = $clog2(NSRC);

   // bit position = priority rank (0 most urgent)
   typedef enum logic [IDW-1:0] {
      SRC_RST   = 4'd0,  SRC_MCHK = 4'd1,  SRC_DBG  = 4'd2,  SRC_HDEC = 4'd3,
      SRC_CEXT  = 4'd4,  SRC_WDOG = 4'd5,  SRC_CDB  = 4'd6,  SRC_FIT  = 4'd7,
      SRC_PIT   = 4'd8,  SRC_DEC  = 4'd9,  SRC_EXT  = 4'd10, SRC_DB   = 4'd11,
      SRC_PERF  = 4'd12, SRC_THERM = 4'd13
   } src_e;

   typedef enum logic [2:0] {
      CLR_ALWAYS, CLR_NEVER, CLR_DEC_CFG, CLR_EXT_CFG, CLR_CEXT_CFG
   } clr_pol_e;

   function automatic clr_pol_e clr_policy(int unsigned k);
      case (k)
         int'(SRC_HDEC): return CLR_NEVER;
         int'(SRC_DEC):  return CLR_DEC_CFG;
         int'(SRC_EXT):  return CLR_EXT_CFG;
         int'(SRC_CEXT): return CLR_CEXT_CFG;
         default:        return CLR_ALWAYS;
      endcase
   endfunction
endpackage

// File: rtl/irqd_pend_bank.sv
module irqd_pend_bank #(
   parameter int unsigned N = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   initial begin
      if (N < 2) $error("irqd_pend_bank: N must be at least 2");
   end

   for (genvar k = 0; k < N; k++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (rst)           q <= 1'b0;
         else if (set_i[k]) q <= 1'b1;
         else if (clr_i[k]) q <= 1'b0;
      end
      assign pend_o[k] = q;

      // R10: a set always leaves the bit pending next cycle
      p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
         set_i[k] |=> pend_o[k]);
   end
endmodule

// File: rtl/irqd_prio_pick.sv
module irqd_prio_pick #(
   parameter int unsigned N   = 14,
   parameter int unsigned IDW = $clog2(N)
) (
   input  logic [N-1:0]   req_i,
   output logic           found_o,
   output logic [IDW-1:0] idx_o,
   output logic [N-1:0]   oh_o
);
   initial begin
      if (N < 2) $error("irqd_prio_pick: N must be at least 2");
      if ((1 << IDW) < N) $error("irqd_prio_pick: IDW too narrow");
   end

   // scan from least urgent to most urgent so the lowest index wins
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDW'(i);
         end
      end
   end

   for (genvar k = 0; k < N; k++) begin : g_oh
      if (k == 0) begin : g_top
         assign oh_o[k] = req_i[k];
      end else begin : g_rest
         assign oh_o[k] = req_i[k] & ~(|req_i[k-1:0]);
      end
   end
endmodule

// File: rtl/irqd_clr_policy.sv
module irqd_clr_policy
   import irqd_pkg::*;
#(
   parameter int unsigned N = NSRC
) (
   input  logic         accept_i,
   input  logic [N-1:0] pick_oh_i,
   input  logic         dec_autoclr_i,
   input  logic         ext_lvl_i,
   input  logic         cext_lvl_i,
   output logic [N-1:0] clr_o
);
   logic [N-1:0] clearable;

   for (genvar k = 0; k < N; k++) begin : g_pol
      localparam clr_pol_e POL = clr_policy(k);
      if (POL == CLR_ALWAYS) begin : g_always
         assign clearable[k] = 1'b1;
      end else if (POL == CLR_NEVER) begin : g_never
         assign clearable[k] = 1'b0;
      end else if (POL == CLR_DEC_CFG) begin : g_dec
         assign clearable[k] = dec_autoclr_i;
      end else if (POL == CLR_EXT_CFG) begin : g_ext
         assign clearable[k] = ~ext_lvl_i;
      end else begin : g_cext
         assign clearable[k] = ~cext_lvl_i;
      end
   end

   assign clr_o = accept_i ? (pick_oh_i & clearable) : '0;
endmodule

// File: rtl/irq_dispatch_sel.sv
module irq_dispatch_sel
   import irqd_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] irq_set_i,
   input  logic            take_i,
   input  logic            ack_rdy_i,
   input  logic            dec_autoclr_i,
   input  logic            ext_lvl_i,
   input  logic            cext_lvl_i,
   input  logic            hdec_en_i,
   input  logic            ee_i,
   input  logic            hv_i,
   input  logic            pr_i,
   output logic            disp_vld_o,
   output logic [IDW-1:0]  disp_id_o,
   output logic [NSRC-1:0] disp_oh_o,
   output logic            none_pend_o
);
   logic [NSRC-1:0] pend_q, clr_mask, elig, pick_oh;
   logic [IDW-1:0]  pick_idx;
   logic            found, hdec_ok, free, accept;
   logic            vld_q;
   logic [IDW-1:0]  id_q;
   logic [NSRC-1:0] oh_q;

   irqd_pend_bank #(.N(NSRC)) u_bank (
      .clk(clk), .rst(rst), .set_i(irq_set_i), .clr_i(clr_mask), .pend_o(pend_q));

   assign hdec_ok = hdec_en_i & (ee_i | ~hv_i | pr_i);

   always_comb begin
      elig = pend_q;
      elig[SRC_HDEC] = pend_q[SRC_HDEC] & hdec_ok;
   end

   irqd_prio_pick #(.N(NSRC), .IDW(IDW)) u_pick (
      .req_i(elig), .found_o(found), .idx_o(pick_idx), .oh_o(pick_oh));

   assign free   = ~vld_q | ack_rdy_i;
   assign accept = take_i & free & found;

   irqd_clr_policy #(.N(NSRC)) u_pol (
      .accept_i(accept), .pick_oh_i(pick_oh), .dec_autoclr_i(dec_autoclr_i),
      .ext_lvl_i(ext_lvl_i), .cext_lvl_i(cext_lvl_i), .clr_o(clr_mask));

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         id_q  <= '0;
         oh_q  <= '0;
      end else if (accept) begin
         vld_q <= 1'b1;
         id_q  <= pick_idx;
         oh_q  <= pick_oh;
      end else if (ack_rdy_i) begin
         vld_q <= 1'b0;
      end
   end

   assign disp_vld_o  = vld_q;
   assign disp_id_o   = id_q;
   assign disp_oh_o   = oh_q;
   assign none_pend_o = ~(|pend_q);

   // R4: held output is stable until acknowledged
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      disp_vld_o && !ack_rdy_i |=> disp_vld_o && $stable(disp_id_o));

   // R3: while busy, pending bits only gain set strobes
   p_busy_r3: assert property (@(posedge clk) disable iff (rst)
      disp_vld_o && !ack_rdy_i |=> pend_q == ($past(pend_q) | $past(irq_set_i)));

   // R6: hypervisor decrementer chosen only when gate is open
   p_hdec_gate_r6: assert property (@(posedge clk) disable iff (rst)
      accept && pick_idx == SRC_HDEC |-> hdec_en_i && (ee_i || !hv_i || pr_i));

   // R7: taking the hypervisor decrementer leaves it pending
   p_hdec_keep_r7: assert property (@(posedge clk) disable iff (rst)
      accept && pick_idx == SRC_HDEC |=> pend_q[SRC_HDEC]);

   // R12: one-hot view agrees with the encoded id
   p_oh_r12: assert property (@(posedge clk) disable iff (rst)
      disp_vld_o |-> $countones(disp_oh_o) == 1 && disp_oh_o[disp_id_o]);

   // R11: nothing pending means no later dispatch can start
   p_idle_r11: assert property (@(posedge clk) disable iff (rst)
      none_pend_o && irq_set_i == '0 && !disp_vld_o |=> !disp_vld_o);
endmodule

// File: tb/irq_dispatch_sel_tb.sv
module irq_dispatch_sel_tb;
   localparam int N = 14;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0] irq_set_i = '0;
   logic take_i = 0, ack_rdy_i = 0, dec_autoclr_i = 0, ext_lvl_i = 0, cext_lvl_i = 0;
   logic hdec_en_i = 0, ee_i = 0, hv_i = 0, pr_i = 0;
   logic disp_vld_o, none_pend_o;
   logic [3:0] disp_id_o;
   logic [N-1:0] disp_oh_o;
   int errors = 0, checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_dispatch_sel u_dut (.*);

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst = 1; tick(); tick(); rst = 0;
   endtask

   task automatic raise(logic [N-1:0] m);
      irq_set_i = m; tick(); irq_set_i = '0;
   endtask

   task automatic take();
      take_i = 1; tick(); take_i = 0;
   endtask

   task automatic ack();
      ack_rdy_i = 1; tick(); ack_rdy_i = 0;
   endtask

   function automatic bit exp_clear(int k, bit cfg);
      case (k)
         3: return 0;
         9: return cfg;
         4, 10: return !cfg;
         default: return 1;
      endcase
   endfunction

   function automatic string clr_tag(int k);
      case (k)
         3: return "R7";
         9: return "R8";
         4, 10: return "R9";
         default: return "R5";
      endcase
   endfunction

   initial begin
      do_reset();
      // R1 reset state
      chk(disp_vld_o == 0, "R1 vld", disp_vld_o, 0);
      chk(none_pend_o == 1, "R1 idle", none_pend_o, 1);

      // each source alone, both config settings
      for (int cfg = 0; cfg < 2; cfg++) begin
         for (int k = 0; k < N; k++) begin
            do_reset();
            dec_autoclr_i = cfg[0]; ext_lvl_i = cfg[0]; cext_lvl_i = cfg[0];
            hdec_en_i = 1; ee_i = 1; hv_i = 1; pr_i = 0;
            raise(N'(1) << k);
            take();
            chk(disp_vld_o == 1 && disp_id_o == k, "R2 single id", disp_id_o, k);
            chk(disp_oh_o == (N'(1) << k), "R12 onehot", int'(disp_oh_o), 1 << k);
            ack();
            chk(disp_vld_o == 0, "R4 drop after ack", disp_vld_o, 0);
            chk(none_pend_o == exp_clear(k, cfg[0]), clr_tag(k), none_pend_o,
                exp_clear(k, cfg[0]));
            if (!exp_clear(k, cfg[0])) begin
               take();
               chk(disp_vld_o == 1 && disp_id_o == k, {clr_tag(k), " still pending"},
                   disp_id_o, k);
               ack();
            end
         end
      end

      // all pairs: lower index wins (R2)
      dec_autoclr_i = 1; ext_lvl_i = 0; cext_lvl_i = 0;
      hdec_en_i = 1; ee_i = 1; hv_i = 1; pr_i = 0;
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            do_reset();
            raise((N'(1) << i) | (N'(1) << j));
            take();
            chk(disp_vld_o == 1 && disp_id_o == i, "R2 pair priority", disp_id_o, i);
            ack();
         end
      end

      // hypervisor decrementer gating sweep (R6)
      for (int g = 0; g < 16; g++) begin
         bit open;
         do_reset();
         hdec_en_i = g[0]; ee_i = g[1]; hv_i = g[2]; pr_i = g[3];
         open = g[0] && (g[1] || !g[2] || g[3]);
         raise((N'(1) << 3) | (N'(1) << 13));
         take();
         chk(disp_vld_o == 1 && disp_id_o == (open ? 3 : 13), "R6 gate",
             disp_id_o, open ? 3 : 13);
         ack();
      end

      // only gated hdec pending: nothing delivered, not idle (R11)
      do_reset();
      hdec_en_i = 0;
      raise(N'(1) << 3);
      take();
      chk(disp_vld_o == 0, "R11 no eligible", disp_vld_o, 0);
      chk(none_pend_o == 0, "R11 still pending", none_pend_o, 0);

      // hold until ready; takes while busy ignored (R3, R4)
      do_reset();
      raise((N'(1) << 7) | (N'(1) << 12));
      take();
      for (int c = 0; c < 3; c++) begin
         take();
         chk(disp_vld_o == 1 && disp_id_o == 7, "R4 hold", disp_id_o, 7);
      end
      ack();
      chk(disp_vld_o == 0, "R3 one per take", disp_vld_o, 0);
      chk(none_pend_o == 0, "R3 busy take kept source 12", none_pend_o, 0);
      take();
      chk(disp_vld_o == 1 && disp_id_o == 12, "R3 next source", disp_id_o, 12);
      // take together with ack delivers back-to-back
      raise(N'(1) << 0);
      take_i = 1; ack_rdy_i = 1; tick(); take_i = 0; ack_rdy_i = 0;
      chk(disp_vld_o == 1 && disp_id_o == 0, "R4 take with ack", disp_id_o, 0);
      ack();
      chk(none_pend_o == 1, "R11 idle after all taken", none_pend_o, 1);

      // set and clear in the same cycle (R10)
      do_reset();
      raise(N'(1) << 5);
      irq_set_i = N'(1) << 5; take_i = 1; tick(); irq_set_i = '0; take_i = 0;
      chk(disp_id_o == 5, "R10 delivered", disp_id_o, 5);
      ack();
      chk(none_pend_o == 0, "R10 set wins", none_pend_o, 0);
      take();
      chk(disp_vld_o == 1 && disp_id_o == 5, "R10 redelivered", disp_id_o, 5);
      ack();

      done = 1;
   end

   initial begin
      for (int c = 0; c < 50000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule